// File: doc/BRIEF.md
# Ring-Walking Transmit DMA Engine

This block moves outgoing frames from memory to a byte stream. Software builds a circular table of 8-byte descriptors in memory. Each descriptor names a buffer and its length, and marks whether the buffer starts a frame, ends a frame, should raise an interrupt, or is the final slot of the table. Software then hands the table to the engine by giving it the table's page and a tail offset. The engine reads one descriptor after another over a simple memory read port. It sends each buffer one byte at a time on a valid/ready stream, marking the first and last byte of each frame.

Software posts work by moving the tail offset forward. The engine halts when its own position reaches the tail, and it wraps to the start of the table after a slot flagged as the last one. A control word holds an enable bit and a suspend bit. Clearing enable stops the engine at once. Setting suspend lets the engine finish the frame in progress and then park. A status view reports the engine state, the offset of the next descriptor to fetch, and the offset of the descriptor whose bytes are on the stream.

Top module: `txdma_engine`

## Requirements
- R1: While reset is held and after its release, with the control word zero, the engine reports state 0 (disabled), drives no stream beat, issues no memory read and keeps `irq` low.
- R2: Control word bit 0 is enable and bit 1 is suspend. A control word of all ones means the engine is absent: `eng_enabled` is 0 and the engine stays disabled. Otherwise `eng_enabled` equals bit 0.
- R3: When the engine goes from disabled to enabled, it latches `ring_page` as the table base and sets its current offset to 0. The state codes are 0 disabled, 1 active, 2 idle (parked by suspend) and 3 stopped (caught up with the tail).
- R4: A descriptor occupies 8 bytes at base + offset. Word +0 is the control word: bits [12:0] hold the byte count, bit 31 is start-of-frame, bit 30 is end-of-frame, bit 29 is interrupt-on-completion and bit 28 is end-of-table. Word +4 is the buffer byte address. A read requested in one cycle returns its 32-bit little-endian word on `mem_rd_data` in the next cycle.
- R5: The buffer bytes leave in rising address order, from any start alignment, one byte per accepted beat. While `out_valid` is high and `out_ready` is low, `out_data` holds steady and the engine makes no memory read.
- R6: `out_first` marks the first byte of a descriptor that carries start-of-frame. `out_last` marks the final byte of a descriptor that carries end-of-frame.
- R7: After a descriptor completes, the current offset advances by 8, or returns to 0 if the descriptor had end-of-table set. The engine reports stopped when its offset equals `tail_ofs`, and it resumes when the tail moves.
- R8: A descriptor with a byte count of 0 completes without sending any byte. It still advances the offset and still honours its interrupt flag.
- R9: `irq` pulses for exactly one cycle when a descriptor carrying interrupt-on-completion completes, that is, after its last byte has been accepted. A descriptor without the flag raises no pulse.
- R10: With suspend set, the engine finishes any frame already begun (from start-of-frame through end-of-frame) and then parks in idle without fetching more. Clearing suspend resumes at the next unsent descriptor.
- R11: Clearing enable puts the engine in the disabled state on the next clock edge. The stream beat drops and the descriptor in progress is abandoned.
- R12: During every stream beat, `st_act_ofs` gives the table offset of the descriptor whose byte is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Control word: bit 0 enable, bit 1 suspend; all ones means absent |
| ring_page | input | ADDR_W-RING_ALIGN_LOG2 | Table base address in units of the table alignment |
| tail_ofs | input | RING_ALIGN_LOG2 | Byte offset of the first descriptor not yet posted |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Word-aligned byte address of the read |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| irq | output | 1 | One-cycle completion pulse |
| eng_enabled | output | 1 | Enable as seen by the engine |
| st_state | output | 2 | Engine state code |
| st_cur_ofs | output | RING_ALIGN_LOG2 | Offset of the next descriptor to fetch |
| st_act_ofs | output | RING_ALIGN_LOG2 | Offset of the descriptor being streamed |

## Verification
A wrong current offset shows up at the port within one descriptor. Either the stopped state comes with an offset that differs from the tail, or the next descriptor read goes to the wrong address, so the bytes the bench expects do not match. A stale frame-progress flag shows up as a park in idle in the middle of a frame when suspend is set, or as a missing park. The bench sees this as leftover expected bytes or as extra bytes on the stream. A wrong byte counter or pointer corrupts the very next beat: the data, the `out_last` mark or the count of completion pulses differs from the bench model.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;

  typedef enum logic [3:0] {
    S_DIS, S_PICK, S_IDLE, S_STOP,
    S_RC, S_CC, S_RA, S_CA,
    S_RD, S_CD, S_SEND, S_DONE
  } txs_t;

  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_RUN  = 2'd1;
  localparam logic [1:0] ST_PARK = 2'd2;
  localparam logic [1:0] ST_HALT = 2'd3;

  localparam int EN_POS   = 0;
  localparam int SUSP_POS = 1;
  localparam int SOF_POS  = 31;
  localparam int EOF_POS  = 30;
  localparam int IOC_POS  = 29;
  localparam int EOT_POS  = 28;

  // picks one byte of a little-endian word
  function automatic logic [7:0] f_lane(logic [31:0] w, logic [1:0] sel);
    return w[{sel, 3'b000} +: 8];
  endfunction

  // decision taken between descriptors
  function automatic txs_t f_pick(logic susp, logic in_frame, logic caught_up);
    if (susp && !in_frame) return S_IDLE;
    if (caught_up)         return S_STOP;
    return S_RC;
  endfunction

  function automatic logic [1:0] f_status(txs_t s);
    case (s)
      S_DIS:   return ST_OFF;
      S_IDLE:  return ST_PARK;
      S_STOP:  return ST_HALT;
      default: return ST_RUN;
    endcase
  endfunction

endpackage

// File: rtl/txdma_ctl_if.sv
`timescale 1ns/1ps
module txdma_ctl_if
  import txdma_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [CW-1:0] ctrl_word,
  output logic          eng_en,
  output logic          eng_susp
);
  logic absent;

  assign absent   = &ctrl_word;
  assign eng_en   = !absent && ctrl_word[EN_POS];
  assign eng_susp = !absent && ctrl_word[SUSP_POS];
endmodule

// File: rtl/txdma_ring_ptr.sv
`timescale 1ns/1ps
module txdma_ring_ptr #(
  parameter int PAGE_W     = 20,
  parameter int OFS_W      = 12,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              step,
  input  logic              step_eot,
  output logic [PAGE_W-1:0] page_q,
  output logic [OFS_W-1:0]  cur_ofs
);
  function automatic logic [OFS_W-1:0] f_adv(logic [OFS_W-1:0] cur, logic eot);
    return eot ? '0 : cur + OFS_W'(DESC_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      cur_ofs <= '0;
    end else if (load) begin
      page_q  <= page_in;
      cur_ofs <= '0;
    end else if (step) begin
      cur_ofs <= f_adv(cur_ofs, step_eot);
    end
  end
endmodule

// File: rtl/txdma_engine.sv
`timescale 1ns/1ps
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int RING_ALIGN_LOG2 = 12,
  parameter int BC_W            = 13
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [31:0]                       ctrl_word,
  input  logic [ADDR_W-RING_ALIGN_LOG2-1:0] ring_page,
  input  logic [RING_ALIGN_LOG2-1:0]        tail_ofs,
  output logic                              mem_rd_en,
  output logic [ADDR_W-1:0]                 mem_rd_addr,
  input  logic [31:0]                       mem_rd_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [7:0]                        out_data,
  output logic                              out_first,
  output logic                              out_last,
  output logic                              irq,
  output logic                              eng_enabled,
  output logic [1:0]                        st_state,
  output logic [RING_ALIGN_LOG2-1:0]        st_cur_ofs,
  output logic [RING_ALIGN_LOG2-1:0]        st_act_ofs
);
  localparam int OFS_W      = RING_ALIGN_LOG2;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int DESC_BYTES = 8;

  txs_t              state;
  logic              eng_en, eng_susp;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  cur;
  logic [OFS_W-1:0]  act_q;
  logic [BC_W-1:0]   d_bc, remain;
  logic [ADDR_W-1:0] dptr;
  logic              f_sof, f_eof, f_ioc, f_eot;
  logic              first_pend, in_frame;
  logic [7:0]        obyte;

  // named internal events
  logic load_ring, desc_done, beat, caught_up, final_byte;
  logic unused_ctl_bits;

  assign load_ring  = (state == S_DIS) && eng_en;
  assign desc_done  = (state == S_DONE);
  assign beat       = (state == S_SEND) && out_ready;
  assign final_byte = (remain == BC_W'(1));
  assign caught_up  = (cur == tail_ofs);
  assign unused_ctl_bits = ^mem_rd_data[EOT_POS-1:BC_W];

  txdma_ctl_if #(.CW(32)) u_ctl (
    .ctrl_word (ctrl_word),
    .eng_en    (eng_en),
    .eng_susp  (eng_susp)
  );

  txdma_ring_ptr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DESC_BYTES(DESC_BYTES)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ring),
    .page_in  (ring_page),
    .step     (desc_done),
    .step_eot (f_eot),
    .page_q   (page_q),
    .cur_ofs  (cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_DIS;
      d_bc       <= '0;
      remain     <= '0;
      dptr       <= '0;
      {f_sof, f_eof, f_ioc, f_eot} <= '0;
      first_pend <= 1'b0;
      in_frame   <= 1'b0;
      obyte      <= '0;
      act_q      <= '0;
    end else if (!eng_en) begin
      state <= S_DIS;
    end else begin
      case (state)
        S_DIS: begin
          state    <= S_PICK;
          in_frame <= 1'b0;
        end
        S_PICK, S_IDLE, S_STOP: state <= f_pick(eng_susp, in_frame, caught_up);
        S_RC: state <= S_CC;
        S_CC: begin
          d_bc  <= mem_rd_data[BC_W-1:0];
          f_sof <= mem_rd_data[SOF_POS];
          f_eof <= mem_rd_data[EOF_POS];
          f_ioc <= mem_rd_data[IOC_POS];
          f_eot <= mem_rd_data[EOT_POS];
          state <= S_RA;
        end
        S_RA: state <= S_CA;
        S_CA: begin
          dptr       <= mem_rd_data[ADDR_W-1:0];
          remain     <= d_bc;
          first_pend <= 1'b1;
          act_q      <= cur;
          state      <= (d_bc == '0) ? S_DONE : S_RD;
        end
        S_RD: state <= S_CD;
        S_CD: begin
          obyte <= f_lane(mem_rd_data, dptr[1:0]);
          state <= S_SEND;
        end
        S_SEND: if (beat) begin
          dptr       <= dptr + ADDR_W'(1);
          remain     <= remain - BC_W'(1);
          first_pend <= 1'b0;
          state      <= final_byte ? S_DONE : S_RD;
        end
        S_DONE: begin
          if (f_eof)      in_frame <= 1'b0;
          else if (f_sof) in_frame <= 1'b1;
          state <= S_PICK;
        end
        default: state <= S_DIS;
      endcase
    end
  end

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    case (state)
      S_RC: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = {page_q, cur};
      end
      S_RA: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = {page_q, cur[OFS_W-1:3], 3'b100};
      end
      S_RD: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = {dptr[ADDR_W-1:2], 2'b00};
      end
      default: ;
    endcase
  end

  assign out_valid   = (state == S_SEND);
  assign out_data    = obyte;
  assign out_first   = out_valid && f_sof && first_pend;
  assign out_last    = out_valid && f_eof && final_byte;
  assign irq         = desc_done && f_ioc;
  assign eng_enabled = eng_en;
  assign st_state    = f_status(state);
  assign st_cur_ofs  = cur;
  assign st_act_ofs  = act_q;
endmodule

// File: rtl/txdma_sva.sv
`timescale 1ns/1ps
module txdma_sva #(
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_word,
  input logic [OFS_W-1:0] tail_ofs,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             mem_rd_en,
  input logic             irq,
  input logic             eng_enabled,
  input logic [1:0]       st_state,
  input logic [OFS_W-1:0] st_cur_ofs
);
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 2'd0) |-> (!out_valid && !mem_rd_en && !irq));

  assert_absent_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word == 32'hFFFF_FFFF) |-> !eng_enabled);

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n || !eng_enabled)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_read_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && mem_rd_en));

  assert_stop_at_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_state) != 2'd3) && (st_state == 2'd3)) |-> (st_cur_ofs == $past(tail_ofs)));

  assert_ofs_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_cur_ofs[2:0] == 3'b000);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_disable_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enabled |=> (st_state == 2'd0));
endmodule

bind txdma_engine txdma_sva #(.OFS_W(RING_ALIGN_LOG2)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_word   (ctrl_word),
  .tail_ofs    (tail_ofs),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .mem_rd_en   (mem_rd_en),
  .irq         (irq),
  .eng_enabled (eng_enabled),
  .st_state    (st_state),
  .st_cur_ofs  (st_cur_ofs)
);

// File: tb/sim_txdma_engine.sv
`timescale 1ns/1ps
module sim_txdma_engine;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int RING_N = 4;
  localparam int RING_BASE = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       ctrl_word = '0;
  logic [PAGE_W-1:0] ring_page = '0;
  logic [OFS_W-1:0]  tail_ofs = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [31:0]       mem_rd_data = '0;
  logic              out_valid, out_ready = 1'b0;
  logic [7:0]        out_data;
  logic              out_first, out_last, irq, eng_enabled;
  logic [1:0]        st_state;
  logic [OFS_W-1:0]  st_cur_ofs, st_act_ofs;

  always #5 clk = ~clk;

  txdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ring_page(ring_page),
    .tail_ofs(tail_ofs), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last), .irq(irq),
    .eng_enabled(eng_enabled), .st_state(st_state), .st_cur_ofs(st_cur_ofs),
    .st_act_ofs(st_act_ofs)
  );

  logic [7:0] bmem [0:8191];
  logic [7:0] exp_b[$];
  bit         exp_f[$];
  bit         exp_l[$];
  int         exp_a[$];
  int n_chk = 0, n_err = 0, irq_cnt = 0, exp_irq = 0, sw_idx = 0, ready_mode = 0;
  bit done_flag = 0;

  // memory model: one-cycle read latency, little-endian words
  always @(posedge clk) begin
    if (mem_rd_en) begin
      int a;
      a = int'(mem_rd_addr[12:0]);
      mem_rd_data <= {bmem[a+3], bmem[a+2], bmem[a+1], bmem[a]};
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stream monitor
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_b.size() == 0) chk(0, "R5", "unexpected byte", out_data, 0);
      else begin
        logic [7:0] eb; bit ef, el; int ea;
        eb = exp_b.pop_front(); ef = exp_f.pop_front();
        el = exp_l.pop_front(); ea = exp_a.pop_front();
        chk(out_data == eb, "R5", "data", out_data, eb);
        chk(out_first == ef, "R6", "first", out_first, ef);
        chk(out_last == el, "R6", "last", out_last, el);
        chk(int'(st_act_ofs) == ea, "R12", "act ofs", st_act_ofs, ea);
      end
    end
    if (rst_n && irq) irq_cnt++;
  end

  function automatic logic [31:0] f_ctrl(int len, bit sof, bit eof, bit ioc, bit eot);
    logic [31:0] w;
    w = 32'(len) & 32'h1FFF;
    w[31] = sof; w[30] = eof; w[29] = ioc; w[28] = eot;
    return w;
  endfunction

  task automatic add_desc(input int len, input bit sof, input bit eof, input bit ioc);
    int ba = int'($urandom_range(0, 3900));
    int dofs = sw_idx * 8;
    int da = RING_BASE + dofs;
    logic [31:0] cw = f_ctrl(len, sof, eof, ioc, sw_idx == RING_N - 1);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      bmem[ba+i] = b;
      exp_b.push_back(b);
      exp_f.push_back(sof && i == 0);
      exp_l.push_back(eof && i == len - 1);
      exp_a.push_back(dofs);
    end
    for (int k = 0; k < 4; k++) begin
      bmem[da+k]   = cw[8*k +: 8];
      bmem[da+4+k] = 8'(ba >> (8*k));
    end
    if (ioc) exp_irq++;
    sw_idx = (sw_idx + 1) % RING_N;
  endtask

  task automatic post();
    @(negedge clk);
    tail_ofs = OFS_W'(sw_idx * 8);
  endtask

  task automatic wait_drain(input string req);
    bit ok = 0;
    for (int t = 0; t < 6000 && !ok; t++) begin
      @(negedge clk);
      ok = (exp_b.size() == 0) && (st_state == 2'd3);
    end
    chk(ok, req, "drain to stopped", exp_b.size(), 0);
  endtask

  task automatic wait_valid(input string req);
    bit ok = 0;
    for (int t = 0; t < 2000 && !ok; t++) begin
      @(negedge clk);
      ok = out_valid;
    end
    chk(ok, req, "stream start", out_valid, 1);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "timeout", 0, 1);
    summary();
  end

  initial begin
    int idx_b;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8192; i++) bmem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(st_state == 2'd0, "R1", "state in reset", st_state, 0);
    chk(!out_valid && !mem_rd_en && !irq, "R1", "quiet in reset", {out_valid, mem_rd_en, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(st_state == 2'd0 && !mem_rd_en, "R1", "idle after reset", st_state, 0);

    // R2: absent word and suspend-only word
    ring_page = PAGE_W'(1);
    ctrl_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(!eng_enabled, "R2", "all-ones absent", eng_enabled, 0);
    chk(st_state == 2'd0, "R2", "absent stays off", st_state, 0);
    ctrl_word = 32'h0000_0002;
    repeat (2) @(negedge clk);
    chk(!eng_enabled && st_state == 2'd0, "R2", "suspend only", eng_enabled, 0);

    // R3: enable loads base, offset 0, stopped
    ctrl_word = 32'h0000_0001;
    @(negedge clk);
    chk(eng_enabled, "R2", "enable bit", eng_enabled, 1);
    chk(st_state == 2'd1 && st_cur_ofs == '0, "R3", "load on enable", st_state, 1);
    @(negedge clk);
    chk(st_state == 2'd3, "R3", "stopped at tail", st_state, 3);

    // R4 R5 R6 R7 R9: random frames around the ring
    for (int r = 0; r < 14; r++) begin
      ready_mode = int'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) begin
        add_desc(int'($urandom_range(1, 30)), 1, 0, 0);
        add_desc(int'($urandom_range(1, 30)), 0, 1, 1);
      end else begin
        add_desc(int'($urandom_range(1, 40)), 1, 1, 1'($urandom % 2));
      end
      post();
      wait_drain("R4");
      chk(int'(st_cur_ofs) == sw_idx * 8, "R7", "offset after wrap", st_cur_ofs, sw_idx * 8);
      chk(irq_cnt == exp_irq, "R9", "irq count", irq_cnt, exp_irq);
    end

    // R8: zero-length descriptor with interrupt, then a short frame
    ready_mode = 0;
    add_desc(0, 0, 0, 1);
    add_desc(3, 1, 1, 0);
    post();
    wait_drain("R8");
    chk(irq_cnt == exp_irq, "R8", "zero-length irq", irq_cnt, exp_irq);
    chk(int'(st_cur_ofs) == sw_idx * 8, "R8", "zero-length advance", st_cur_ofs, sw_idx * 8);

    // R10: suspend parks at frame boundary
    idx_b = (sw_idx + 2) % RING_N;
    add_desc(12, 1, 0, 0);
    add_desc(12, 0, 1, 1);
    add_desc(5, 1, 1, 1);
    post();
    wait_valid("R10");
    ctrl_word = 32'h0000_0003;
    begin
      bit ok = 0;
      for (int t = 0; t < 2000 && !ok; t++) begin
        @(negedge clk);
        ok = (st_state == 2'd2);
      end
      chk(ok, "R10", "parked idle", st_state, 2);
    end
    chk(exp_b.size() == 5, "R10", "frame finished first", exp_b.size(), 5);
    repeat (10) @(negedge clk);
    chk(st_state == 2'd2 && !out_valid, "R10", "stays parked", st_state, 2);
    chk(exp_b.size() == 5, "R10", "no bytes while parked", exp_b.size(), 5);
    chk(int'(st_cur_ofs) == idx_b * 8, "R10", "parked offset", st_cur_ofs, idx_b * 8);
    ctrl_word = 32'h0000_0001;
    wait_drain("R10");
    chk(irq_cnt == exp_irq, "R9", "irq after resume", irq_cnt, exp_irq);

    // R11: disable abandons a stalled beat
    ready_mode = 2;
    add_desc(10, 1, 1, 0);
    post();
    wait_valid("R11");
    ctrl_word = 32'h0000_0000;
    @(negedge clk);
    chk(st_state == 2'd0, "R11", "disabled next edge", st_state, 0);
    chk(!out_valid, "R11", "beat dropped", out_valid, 0);
    exp_b.delete(); exp_f.delete(); exp_l.delete(); exp_a.delete();

    // R3: re-enable restarts at offset 0
    sw_idx = 0;
    tail_ofs = '0;
    ctrl_word = 32'h0000_0001;
    repeat (2) @(negedge clk);
    chk(st_state == 2'd3 && st_cur_ofs == '0, "R3", "restart at zero", st_cur_ofs, 0);
    ready_mode = 1;
    add_desc(7, 1, 1, 1);
    post();
    wait_drain("R3");
    chk(irq_cnt == exp_irq, "R9", "irq after restart", irq_cnt, exp_irq);
    summary();
  end
endmodule